// File: doc/BRIEF.md
# Affinity-Constrained Counter Slot Allocator

This block places performance events onto a bank of hardware counter slots. Each event is named by an 8-bit code, and each code may only be hosted by certain slots: most codes accept a wide default range, while some are tied to a short irregular list or to a single slot. On an allocate request the block looks up the permitted slots for the code in an internal combinational table. It then removes the slots already taken and grants the lowest-numbered slot that is left. In the same step it records that slot as taken.

Software or a neighbouring control block releases a slot with a free request that carries the slot index. Allocate and free may arrive in the same cycle, and both take effect. The allocation decision, however, is always made against the occupancy held at the start of that cycle. The response arrives one clock after the request: a valid pulse, a grant flag and the slot index. When nothing could be granted, the index reads all-ones.

Top module: `slot_alloc`

## Requirements
- R1: After reset no slot is occupied, and rsp_valid and rsp_grant read 0 with rsp_idx all-ones.
- R2: A code with no special rule may only be placed on slots 2 through 9. Slots 0 and 1 are never granted to it.
- R3: Code 0x02 may use slot 0 and slots 2 through 9, but not slot 1.
- R4: Code 0x8C may use only slot 1 and slot 7.
- R5: Codes 0x8D, 0x8E, 0x8F, 0x90, 0x93 and 0x94 may use only slots 5, 6 and 7.
- R6: Codes 0xF5, 0xF6, 0xF7 and 0xFD may use only slots 2, 4 and 6. Code 0xF8 may use only slots 2 through 7.
- R7: Codes 0x01, 0x96, 0x97, 0x9A, 0x9B and 0x9F may use slot 7 only.
- R8: A grant always names the lowest-indexed slot that the code permits and that is unoccupied, and that slot is occupied from then on.
- R9: When no permitted slot is free, rsp_grant is 0 and rsp_idx is all-ones (0xF at the default width), and occupancy does not change.
- R10: A free request with an index below 10 makes that slot unoccupied. A free request with a larger index has no effect.
- R11: Allocate and free in the same cycle are both applied. A slot freed in that cycle cannot be granted to that cycle's allocation, only to a later one.
- R12: rsp_valid is high for exactly the one cycle after each cycle in which alloc_req is high. Back-to-back requests each get their own response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Allocate request strobe |
| alloc_code | input | CODE_W (8) | Event code to be placed |
| free_req | input | 1 | Release request strobe |
| free_idx | input | IDX_W (4) | Slot to release |
| rsp_valid | output | 1 | Response to the previous cycle's allocate request |
| rsp_grant | output | 1 | 1 if a slot was granted |
| rsp_idx | output | IDX_W (4) | Granted slot, all-ones on failure |

## Verification
On every cycle the assertions check the following:
- the response pulse tracks the request one clock later;
- any granted slot was both permitted and unoccupied;
- a granted slot reads as occupied afterwards;
- a failure carries the all-ones index and leaves occupancy untouched;
- a released in-range slot reads free unless it was granted in that same cycle;
- the picker's choice is one-hot and has no lower candidate.

The per-code affinity sets cannot be shown by those properties, because the properties lean on the block's own table. The bench scenarios therefore walk each code class through a chosen fill order and compare every grant against hand-derived slot numbers. The same scenarios cover the same-cycle free and allocate ordering and the out-of-range release.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

   // Two ways to build the lowest-set-bit picker
   typedef enum logic {
      PICK_SCAN    = 1'b0,
      PICK_ISOLATE = 1'b1
   } pick_style_e;

   localparam int MAX_SLOTS = 64;

   // Contiguous run of ones from bit lo to bit hi inclusive
   function automatic logic [MAX_SLOTS-1:0] span_mask(input int lo, input int hi);
      logic [MAX_SLOTS-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_SLOTS; i++) begin
         if (i >= lo && i <= hi) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/slot_affinity_lut.sv
module slot_affinity_lut
   import slot_alloc_pkg::*;
#(
   parameter int NUM_SLOTS = 10,
   parameter int CODE_W    = 8
) (
   input  logic [CODE_W-1:0]    code,
   output logic [NUM_SLOTS-1:0] allow
);

   if (CODE_W != 8) begin : g_bad_code_w
      $error("slot_affinity_lut: CODE_W must be 8");
   end
   if (NUM_SLOTS < 10 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("slot_affinity_lut: NUM_SLOTS must be within 10..64");
   end

   localparam logic [MAX_SLOTS-1:0] W_DEFAULT = span_mask(2, NUM_SLOTS - 1);
   localparam logic [MAX_SLOTS-1:0] W_CYCLE   = W_DEFAULT | span_mask(0, 0);
   localparam logic [MAX_SLOTS-1:0] W_INSTR   = span_mask(1, 1) | span_mask(7, 7);
   localparam logic [MAX_SLOTS-1:0] W_BRANCH  = span_mask(5, 7);
   localparam logic [MAX_SLOTS-1:0] W_EVEN    = span_mask(2, 2) | span_mask(4, 4) | span_mask(6, 6);
   localparam logic [MAX_SLOTS-1:0] W_MID     = span_mask(2, 7);
   localparam logic [MAX_SLOTS-1:0] W_SOLO7   = span_mask(7, 7);

   logic [MAX_SLOTS-1:0] wide;

   always_comb begin
      unique case (code)
         8'h02:                                   wide = W_CYCLE;
         8'h8C:                                   wide = W_INSTR;
         8'h8D, 8'h8E, 8'h8F, 8'h90, 8'h93, 8'h94: wide = W_BRANCH;
         8'hF5, 8'hF6, 8'hF7, 8'hFD:              wide = W_EVEN;
         8'hF8:                                   wide = W_MID;
         8'h01, 8'h96, 8'h97, 8'h9A, 8'h9B, 8'h9F: wide = W_SOLO7;
         default:                                 wide = W_DEFAULT;
      endcase
   end

   assign allow = wide[NUM_SLOTS-1:0];

endmodule

// File: rtl/slot_first_fit.sv
module slot_first_fit
   import slot_alloc_pkg::*;
#(
   parameter int          NUM_SLOTS = 10,
   parameter int          IDX_W     = 4,
   parameter pick_style_e STYLE     = PICK_SCAN
) (
   input  logic [NUM_SLOTS-1:0] cand,
   output logic                 found,
   output logic [IDX_W-1:0]     idx,
   output logic [NUM_SLOTS-1:0] onehot
);

   if ((1 << IDX_W) < NUM_SLOTS) begin : g_bad_idx_w
      $error("slot_first_fit: IDX_W too narrow for NUM_SLOTS");
   end

   if (STYLE == PICK_SCAN) begin : g_scan
      // Walk from the top down so the lowest candidate wins last
      always_comb begin
         onehot = '0;
         for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (cand[i]) begin
               onehot    = '0;
               onehot[i] = 1'b1;
            end
         end
      end
   end else begin : g_isolate
      // Two's complement trick keeps only the lowest set bit
      assign onehot = cand & (~cand + {{(NUM_SLOTS-1){1'b0}}, 1'b1});
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (onehot[i]) idx = idx | IDX_W'(i);
      end
   end

   assign found = |cand;

   // Any candidate below the chosen index would break first-fit
   logic lower_hit;
   always_comb begin
      lower_hit = 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (cand[i] && (i < int'(idx))) lower_hit = 1'b1;
      end
   end

   always_comb begin
      assert_onehot_pick_R8: assert ($onehot0(onehot))
         else $error("picker produced more than one slot");
      assert_first_fit_R8: assert (!found || (!lower_hit && 1'(cand >> idx)))
         else $error("picker skipped a lower candidate");
   end

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
   import slot_alloc_pkg::*;
#(
   parameter int          NUM_SLOTS  = 10,
   parameter int          CODE_W     = 8,
   parameter int          IDX_W      = $clog2(NUM_SLOTS + 1),
   parameter pick_style_e PICK_STYLE = PICK_SCAN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic [CODE_W-1:0] alloc_code,
   input  logic              free_req,
   input  logic [IDX_W-1:0]  free_idx,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic [IDX_W-1:0]  rsp_idx
);

   // All-ones must never name a real slot
   if ((1 << IDX_W) <= NUM_SLOTS) begin : g_bad_idx_w
      $error("slot_alloc: IDX_W leaves no spare code for the no-slot marker");
   end

   localparam logic [IDX_W-1:0] NO_SLOT = '1;

   logic [NUM_SLOTS-1:0] used_q;
   logic [NUM_SLOTS-1:0] allow_mask;
   logic [NUM_SLOTS-1:0] cand;
   logic [NUM_SLOTS-1:0] pick_oh;
   logic [NUM_SLOTS-1:0] free_oh;
   logic [NUM_SLOTS-1:0] take_oh;
   logic [IDX_W-1:0]     pick_idx;
   logic                 pick_found;
   logic                 win;

   slot_affinity_lut #(
      .NUM_SLOTS (NUM_SLOTS),
      .CODE_W    (CODE_W)
   ) u_lut (
      .code  (alloc_code),
      .allow (allow_mask)
   );

   // Occupancy is taken from the start of the cycle; same-cycle frees do not feed in
   assign cand = allow_mask & ~used_q;

   slot_first_fit #(
      .NUM_SLOTS (NUM_SLOTS),
      .IDX_W     (IDX_W),
      .STYLE     (PICK_STYLE)
   ) u_pick (
      .cand   (cand),
      .found  (pick_found),
      .idx    (pick_idx),
      .onehot (pick_oh)
   );

   assign win     = alloc_req && pick_found;
   assign take_oh = win ? pick_oh : '0;

   always_comb begin
      free_oh = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (free_req && (free_idx == IDX_W'(i))) free_oh[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_idx   <= NO_SLOT;
      end else begin
         used_q    <= (used_q & ~free_oh) | take_oh;
         rsp_valid <= alloc_req;
         rsp_grant <= win;
         rsp_idx   <= win ? pick_idx : NO_SLOT;
      end
   end

   assert_resp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req |=> rsp_valid);

   assert_no_stray_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_req |=> !rsp_valid);

   assert_grant_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_grant) |-> 1'($past(allow_mask & ~used_q) >> rsp_idx));

   assert_grant_marks_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> 1'(used_q >> rsp_idx));

   assert_fail_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_grant) |-> (rsp_idx == NO_SLOT) && ($past(free_req) || $stable(used_q)));

   assert_free_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (free_req && (int'(free_idx) < NUM_SLOTS)) |=>
         (!1'(used_q >> $past(free_idx)) || (rsp_grant && rsp_idx == $past(free_idx))));

endmodule

// File: tb/tb_slot_alloc.sv
module tb_slot_alloc;
   import slot_alloc_pkg::*;

   localparam int NS = 10;
   localparam int IW = 4;
   localparam logic [IW-1:0] NONE = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_req = 1'b0;
   logic [7:0]    alloc_code = '0;
   logic          free_req = 1'b0;
   logic [IW-1:0] free_idx = '0;
   logic          rsp_valid;
   logic          rsp_grant;
   logic [IW-1:0] rsp_idx;

   slot_alloc #(.NUM_SLOTS(NS), .CODE_W(8), .IDX_W(IW)) dut (
      .clk, .rst_n, .alloc_req, .alloc_code, .free_req, .free_idx,
      .rsp_valid, .rsp_grant, .rsp_idx
   );

   always #5 clk = ~clk;

   typedef struct {
      logic          grant;
      logic [IW-1:0] idx;
      string         tag;
   } exp_t;

   exp_t  sb[$];
   exp_t  mon_e;
   int    n_checks = 0;
   int    n_fail = 0;
   bit    mon_on = 1'b0;
   logic  req_seen;

   task automatic check(bit ok, string tag, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // One cycle of stimulus; allocations queue their expected response
   task automatic step(bit a, logic [7:0] c, bit f, logic [IW-1:0] fi,
                       bit eg, logic [IW-1:0] ei, string tag);
      @(negedge clk);
      alloc_req  = a;
      alloc_code = c;
      free_req   = f;
      free_idx   = fi;
      if (a) sb.push_back('{eg, ei, tag});
   endtask

   task automatic req(logic [7:0] c, bit eg, logic [IW-1:0] ei, string tag);
      step(1'b1, c, 1'b0, '0, eg, ei, tag);
   endtask

   task automatic rel(logic [IW-1:0] fi, string tag);
      step(1'b0, 8'h00, 1'b1, fi, 1'b0, NONE, tag);
   endtask

   task automatic idle();
      step(1'b0, 8'h00, 1'b0, '0, 1'b0, NONE, "idle");
   endtask

   // Monitor: compare each response against the scoreboard head
   always @(posedge clk) begin
      if (mon_on) begin
         req_seen = alloc_req;
         #2;
         check(rsp_valid == req_seen, "R12", "rsp_valid", int'(rsp_valid), int'(req_seen));
         if (rsp_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R12", "response without request", 1, 0);
            end else begin
               mon_e = sb.pop_front();
               check(rsp_grant == mon_e.grant, mon_e.tag, "rsp_grant", int'(rsp_grant), int'(mon_e.grant));
               check(rsp_idx == mon_e.idx, mon_e.tag, "rsp_idx", int'(rsp_idx), int'(mon_e.idx));
            end
         end
      end
   end

   initial begin
      #2000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R12: got %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
      check(rsp_grant == 1'b0, "R1", "rsp_grant in reset", int'(rsp_grant), 0);
      check(rsp_idx == NONE, "R1", "rsp_idx in reset", int'(rsp_idx), int'(NONE));
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // R1/R3: empty bank, code 0x02 takes slot 0, then skips slot 1
      req(8'h02, 1'b1, 4'd0, "R1");
      req(8'h02, 1'b1, 4'd2, "R3");
      // R2: default code never takes slot 1
      req(8'h10, 1'b1, 4'd3, "R2");
      req(8'h10, 1'b1, 4'd4, "R2");
      // R4: instruction code takes 1, then 7, then fails
      req(8'h8C, 1'b1, 4'd1, "R4");
      req(8'h8C, 1'b1, 4'd7, "R4");
      req(8'h8C, 1'b0, NONE, "R9");
      // R5: branch class on 5, 6, then nothing left of 5..7
      req(8'h8D, 1'b1, 4'd5, "R5");
      req(8'h93, 1'b1, 4'd6, "R5");
      req(8'h94, 1'b0, NONE, "R5");
      // R8: remaining default slots, then full
      req(8'h10, 1'b1, 4'd8, "R8");
      req(8'h55, 1'b1, 4'd9, "R8");
      req(8'h10, 1'b0, NONE, "R9");
      req(8'h01, 1'b0, NONE, "R7");
      // R7/R10: release 7, single-slot code gets it back
      rel(4'd7, "R10");
      req(8'h97, 1'b1, 4'd7, "R7");
      // R10: out-of-range release changes nothing
      rel(4'd12, "R10");
      req(8'h10, 1'b0, NONE, "R10");
      // R11: free 4 while allocating 0xF5 in the same cycle
      step(1'b1, 8'hF5, 1'b1, 4'd4, 1'b0, NONE, "R11");
      req(8'hF5, 1'b1, 4'd4, "R11");
      // R6: even-slot codes
      rel(4'd2, "R10");
      rel(4'd6, "R10");
      req(8'hF6, 1'b1, 4'd2, "R6");
      req(8'hFD, 1'b1, 4'd6, "R6");
      req(8'hF7, 1'b0, NONE, "R6");
      // R6: mid-range code
      rel(4'd5, "R10");
      req(8'hF8, 1'b1, 4'd5, "R6");
      // R12: back-to-back grants
      rel(4'd8, "R10");
      rel(4'd9, "R10");
      req(8'h2A, 1'b1, 4'd8, "R12");
      req(8'h2A, 1'b1, 4'd9, "R12");
      // R11: allocation and a free of a different slot both take effect
      rel(4'd1, "R10");
      step(1'b1, 8'h8C, 1'b1, 4'd8, 1'b1, 4'd1, "R11");
      req(8'h33, 1'b1, 4'd8, "R11");
      idle();
      idle();
      idle();
      @(negedge clk);
      check(sb.size() == 0, "R12", "responses outstanding", sb.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule